// File: doc/BRIEF.md
# DRAM Clock-Enable Power-Down Sequencer

This block sits between a DDR SDRAM controller and the memory pins and takes the device into and out of its low-power state by steering the clock-enable line and, for the two cycles of each transition, the command bus. The controller asks for low power with a request line. The block waits until no read or write burst is still running, including its postamble. It then drops clock enable together with a NOP. It records whether every bank was idle at that moment, which gives precharge power-down, or whether some row was still open, which gives active power-down.

Exit happens on a wake request or on a refresh-due input. It also happens, with no request at all, when a residency counter reaches a configured limit, so the refresh interval is never overrun. On exit the block raises clock enable paired with a NOP. It holds off the command scheduler for that cycle and grants the bus again from the following cycle.

Top module: `pd_cke_sequencer`

## Requirements
- R1: After reset, cke is 1, pd_mode is 0, cmd_allowed is 1 and seq_cmd_valid is 0.
- R2: While burst_busy is 1 (burst or its postamble in progress), a power-down request is not taken and cke stays 1. Once burst_busy falls with the request still held, the entry proceeds.
- R3: A request that is taken drives cmd_allowed to 0 in the same cycle. In the next cycle cke is 0 and seq_cmd_valid is 1 with seq_cmd = 3'b111 (NOP, the active-low RAS, CAS, WE lines all high), for that one cycle only.
- R4: pd_mode reads 1 (precharge power-down) if banks_idle was 1 when the request was taken, and 2 (active power-down) otherwise. It holds that value for the whole low-power stay and reads 0 while awake.
- R5: While powered down, pd_req, banks_idle and burst_busy have no effect: cke stays 0, seq_cmd_valid stays 0 and pd_mode does not change.
- R6: A wake_req seen while powered down makes cke 1 in the next cycle together with a NOP (seq_cmd_valid 1, seq_cmd 3'b111), with cmd_allowed 0. In the cycle after that, cmd_allowed is 1 and pd_mode is 0.
- R7: refresh_due seen while powered down causes the same exit sequence as wake_req.
- R8: With no wake or refresh input, the block leaves power-down on its own. cke is 0 for exactly MAX_RESIDENCY+1 consecutive cycles (the entry cycle plus MAX_RESIDENCY powered-down cycles) before the exit NOP.
- R9: While refresh_due is 1, a power-down request is not taken and cke stays 1.
- R10: cmd_allowed is never 1 while cke is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| pd_req | input | 1 | Request to enter power-down |
| wake_req | input | 1 | Request to leave power-down |
| refresh_due | input | 1 | Refresh needed: forces exit and blocks entry |
| banks_idle | input | 1 | All banks precharged (no row open) |
| burst_busy | input | 1 | Read/write burst or its postamble still in progress |
| cke | output | 1 | Clock enable to the memory |
| seq_cmd_valid | output | 1 | Block owns the command bus this cycle |
| seq_cmd | output | 3 | Command on {RAS#, CAS#, WE#} when owned |
| cmd_allowed | output | 1 | Scheduler may issue a normal command |
| pd_mode | output | 2 | 0 awake, 1 precharge power-down, 2 active power-down |

## Verification
A stuck or wrong sequencer state shows up at the ports within one cycle. cke stays high when a request should have been taken, drops while a burst is still busy, or the NOP pair is missing on the cycle where cke changes. A wrongly captured bank state appears as the wrong pd_mode on the very entry cycle. A residency counter that is off by one shows as a low-cke stretch one cycle too long or too short, visible at the exit edge.

// File: rtl/pd_seq_pkg.sv
package pd_seq_pkg;

    typedef enum logic [1:0] {
        ST_AWAKE = 2'd0,
        ST_ENTER = 2'd1,
        ST_DOWN  = 2'd2,
        ST_EXIT  = 2'd3
    } pd_state_e;

    typedef enum logic [1:0] {
        MODE_AWAKE = 2'd0,
        MODE_PRE   = 2'd1,
        MODE_ACT   = 2'd2
    } pd_mode_e;

    // {ras_n, cas_n, we_n}
    localparam logic [2:0] CMD_NOP = 3'b111;

    typedef struct packed {
        logic cke;
        logic own_bus;
        logic sched_ok;
    } pad_ctl_t;

    function automatic pd_mode_e classify(input logic all_idle);
        return all_idle ? MODE_PRE : MODE_ACT;
    endfunction

    function automatic pad_ctl_t decode_state(input pd_state_e st);
        pad_ctl_t c;
        case (st)
            ST_AWAKE: c = '{cke: 1'b1, own_bus: 1'b0, sched_ok: 1'b1};
            ST_ENTER: c = '{cke: 1'b0, own_bus: 1'b1, sched_ok: 1'b0};
            ST_DOWN:  c = '{cke: 1'b0, own_bus: 1'b0, sched_ok: 1'b0};
            default:  c = '{cke: 1'b1, own_bus: 1'b1, sched_ok: 1'b0};
        endcase
        return c;
    endfunction

endpackage

// File: rtl/pd_entry_gate.sv
module pd_entry_gate
    import pd_seq_pkg::*;
(
    input  logic     awake,
    input  logic     pd_req,
    input  logic     burst_busy,
    input  logic     refresh_due,
    input  logic     banks_idle,
    output logic     go,
    output pd_mode_e mode_sel
);
    always_comb begin
        go       = awake && pd_req && !burst_busy && !refresh_due;
        mode_sel = classify(banks_idle);
    end
endmodule

// File: rtl/pd_residency_timer.sv
module pd_residency_timer #(
    parameter int MAX_RESIDENCY = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expire
);
    localparam int CW = $clog2(MAX_RESIDENCY + 1);
    localparam logic [CW-1:0] LAST = CW'(MAX_RESIDENCY - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run) cnt_q <= '0;
        else             cnt_q <= cnt_q + 1'b1;
    end

    assign expire = run && (cnt_q == LAST);
endmodule

// File: rtl/pd_cke_sequencer.sv
module pd_cke_sequencer
    import pd_seq_pkg::*;
#(
    parameter int MAX_RESIDENCY = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pd_req,
    input  logic       wake_req,
    input  logic       refresh_due,
    input  logic       banks_idle,
    input  logic       burst_busy,
    output logic       cke,
    output logic       seq_cmd_valid,
    output logic [2:0] seq_cmd,
    output logic       cmd_allowed,
    output logic [1:0] pd_mode
);
    pd_state_e state_q, state_d;
    pd_mode_e  mode_q, mode_sel;
    logic      go, expire;
    pad_ctl_t  ctl;

    pd_entry_gate u_gate (
        .awake      (state_q == ST_AWAKE),
        .pd_req     (pd_req),
        .burst_busy (burst_busy),
        .refresh_due(refresh_due),
        .banks_idle (banks_idle),
        .go         (go),
        .mode_sel   (mode_sel)
    );

    pd_residency_timer #(.MAX_RESIDENCY(MAX_RESIDENCY)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .run   (state_q == ST_DOWN),
        .expire(expire)
    );

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_AWAKE: if (go) state_d = ST_ENTER;
            ST_ENTER: state_d = ST_DOWN;
            ST_DOWN:  if (wake_req || refresh_due || expire) state_d = ST_EXIT;
            default:  state_d = ST_AWAKE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_AWAKE;
            mode_q  <= MODE_AWAKE;
        end else begin
            state_q <= state_d;
            if (go) mode_q <= mode_sel;
        end
    end

    always_comb begin
        ctl           = decode_state(state_q);
        cke           = ctl.cke;
        seq_cmd_valid = ctl.own_bus;
        seq_cmd       = ctl.own_bus ? CMD_NOP : 3'b000;
        cmd_allowed   = ctl.sched_ok && !go;
        pd_mode       = (state_q == ST_AWAKE) ? 2'(MODE_AWAKE) : 2'(mode_q);
    end
endmodule

// File: rtl/pd_cke_sequencer_chk.sv
module pd_cke_sequencer_chk #(
    parameter int MAX_RESIDENCY = 64
) (
    input logic       clk,
    input logic       rst,
    input logic       cke,
    input logic       seq_cmd_valid,
    input logic [2:0] seq_cmd,
    input logic       cmd_allowed,
    input logic [1:0] pd_mode,
    input logic       burst_busy
);
    localparam int LW = $clog2(MAX_RESIDENCY + 2) + 1;
    localparam logic [LW-1:0] LOW_LIMIT = LW'(MAX_RESIDENCY + 1);

    logic [LW-1:0] low_run;

    always_ff @(posedge clk) begin
        if (rst || cke) low_run <= '0;
        else            low_run <= low_run + 1'b1;
    end

    // R10
    low_cke_no_sched_chk: assert property (@(posedge clk) disable iff (rst)
        !cke |-> !cmd_allowed);

    // R2
    busy_holds_cke_chk: assert property (@(posedge clk) disable iff (rst)
        (cke && burst_busy) |=> cke);

    // R3
    entry_nop_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(cke) |-> (seq_cmd_valid && seq_cmd == 3'b111));

    // R4
    entry_mode_set_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(cke) |-> (pd_mode == 2'd1 || pd_mode == 2'd2));

    // R4
    mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!cke && $past(!cke)) |-> $stable(pd_mode));

    // R6
    exit_nop_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cke) |-> (seq_cmd_valid && seq_cmd == 3'b111 && !cmd_allowed));

    // R6
    exit_then_awake_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cke) |=> (pd_mode == 2'd0 && cke));

    // R8
    residency_bound_chk: assert property (@(posedge clk) disable iff (rst)
        !cke |-> (low_run < LOW_LIMIT));
endmodule

bind pd_cke_sequencer pd_cke_sequencer_chk #(.MAX_RESIDENCY(MAX_RESIDENCY)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cke          (cke),
    .seq_cmd_valid(seq_cmd_valid),
    .seq_cmd      (seq_cmd),
    .cmd_allowed  (cmd_allowed),
    .pd_mode      (pd_mode),
    .burst_busy   (burst_busy)
);

// File: tb/pd_cke_sequencer_bench.sv
module pd_cke_sequencer_bench;
    localparam int PERIOD = 10;
    localparam int RES    = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pd_req = 1'b0, wake_req = 1'b0, refresh_due = 1'b0;
    logic       banks_idle = 1'b1, burst_busy = 1'b0;
    logic       cke, seq_cmd_valid, cmd_allowed;
    logic [2:0] seq_cmd;
    logic [1:0] pd_mode;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    pd_cke_sequencer #(.MAX_RESIDENCY(RES)) u_pd_cke_sequencer (
        .clk(clk), .rst(rst), .pd_req(pd_req), .wake_req(wake_req),
        .refresh_due(refresh_due), .banks_idle(banks_idle),
        .burst_busy(burst_busy), .cke(cke), .seq_cmd_valid(seq_cmd_valid),
        .seq_cmd(seq_cmd), .cmd_allowed(cmd_allowed), .pd_mode(pd_mode)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        chk(cke == 1'b1, "R1 cke", cke, 1);
        chk(pd_mode == 2'd0, "R1 pd_mode", pd_mode, 0);
        chk(cmd_allowed == 1'b1, "R1 cmd_allowed", cmd_allowed, 1);
        chk(seq_cmd_valid == 1'b0, "R1 seq_cmd_valid", seq_cmd_valid, 0);
    endtask

    task automatic t_precharge_cycle();
        banks_idle = 1'b1;
        pd_req = 1'b1;
        #1;
        chk(cmd_allowed == 1'b0, "R3 cmd_allowed on accept", cmd_allowed, 0);
        tick();
        pd_req = 1'b0;
        chk(cke == 1'b0, "R3 cke low", cke, 0);
        chk(seq_cmd_valid == 1'b1 && seq_cmd == 3'b111, "R3 entry NOP", seq_cmd, 7);
        chk(pd_mode == 2'd1, "R4 precharge mode", pd_mode, 1);
        tick();
        chk(seq_cmd_valid == 1'b0, "R3 NOP one cycle", seq_cmd_valid, 0);
        chk(pd_mode == 2'd1, "R4 mode held", pd_mode, 1);
        wake_req = 1'b1;
        tick();
        wake_req = 1'b0;
        chk(cke == 1'b1, "R6 cke high", cke, 1);
        chk(seq_cmd_valid == 1'b1 && seq_cmd == 3'b111, "R6 exit NOP", seq_cmd, 7);
        chk(cmd_allowed == 1'b0, "R6 held off", cmd_allowed, 0);
        tick();
        chk(cmd_allowed == 1'b1, "R6 cmd_allowed after", cmd_allowed, 1);
        chk(pd_mode == 2'd0, "R6 mode awake", pd_mode, 0);
        chk(seq_cmd_valid == 1'b0, "R6 bus released", seq_cmd_valid, 0);
    endtask

    task automatic t_active_ignore();
        banks_idle = 1'b0;
        pd_req = 1'b1;
        tick();
        pd_req = 1'b0;
        chk(pd_mode == 2'd2, "R4 active mode", pd_mode, 2);
        tick();
        pd_req = 1'b1; burst_busy = 1'b1; banks_idle = 1'b1;
        for (int i = 0; i < 3; i++) begin
            tick();
            chk(cke == 1'b0, "R5 cke stays low", cke, 0);
            chk(pd_mode == 2'd2, "R5 mode unchanged", pd_mode, 2);
            chk(seq_cmd_valid == 1'b0, "R5 no bus", seq_cmd_valid, 0);
            chk(cmd_allowed == 1'b0, "R10 no sched while low", cmd_allowed, 0);
        end
        pd_req = 1'b0; burst_busy = 1'b0;
        wake_req = 1'b1;
        tick();
        wake_req = 1'b0;
        chk(cke == 1'b1, "R6 exit from active", cke, 1);
        tick();
    endtask

    task automatic t_busy_refresh();
        burst_busy = 1'b1;
        pd_req = 1'b1;
        for (int i = 0; i < 3; i++) begin
            tick();
            chk(cke == 1'b1, "R2 blocked by burst", cke, 1);
            chk(cmd_allowed == 1'b1, "R2 still schedulable", cmd_allowed, 1);
        end
        burst_busy = 1'b0;
        tick();
        pd_req = 1'b0;
        chk(cke == 1'b0, "R2 entry after burst", cke, 0);
        tick();
        refresh_due = 1'b1;
        tick();
        chk(cke == 1'b1, "R7 refresh exit", cke, 1);
        chk(seq_cmd_valid == 1'b1 && seq_cmd == 3'b111, "R7 exit NOP", seq_cmd, 7);
        pd_req = 1'b1;
        for (int i = 0; i < 3; i++) begin
            tick();
            chk(cke == 1'b1, "R9 refresh blocks entry", cke, 1);
        end
        refresh_due = 1'b0;
        pd_req = 1'b0;
        tick();
    endtask

    task automatic t_residency();
        int lows = 0;
        banks_idle = 1'b1;
        pd_req = 1'b1;
        tick();
        pd_req = 1'b0;
        while (cke == 1'b0 && lows < 50) begin
            lows++;
            tick();
        end
        chk(lows == RES + 1, "R8 low-cke length", lows, RES + 1);
        chk(seq_cmd_valid == 1'b1 && seq_cmd == 3'b111, "R8 exit NOP", seq_cmd, 7);
        tick();
        chk(cmd_allowed == 1'b1, "R8 awake after limit", cmd_allowed, 1);
    endtask

    initial begin
        t_reset();
        t_precharge_cycle();
        t_active_ignore();
        t_busy_refresh();
        t_residency();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule